// File: doc/BRIEF.md
# Dual-Mode Priority Interrupt Controller

This block sits between a group of peripheral interrupt sources and a CPU core. It latches requests from enabled sources, picks one winner, and presents that winner to the CPU as a vector number and a priority level. The non-maskable source is also handled here. Only one request is presented at a time, and it is held until the CPU acknowledges it. The block also gives the mask value that the CPU should load when it takes the request. Stacking state and fetching the vector are left to the CPU.

A mode input selects one of two masking schemes at run time, and both use the same arbiter. In fixed mode, sources rank by index and a single mask bit blocks every maskable source. In level mode, each source carries a programmable 3-bit priority, and a source gets through only when its priority is above the CPU's 3-bit mask level. A request is accepted only on a cycle where the CPU signals an instruction boundary.

Top module: `prio_irq_ctrl`

## Requirements
- R1: `mode_sel` = 0 selects fixed mode, which uses `mask_bit`. `mode_sel` = 1 selects level mode, which uses `mask_lvl` and ignores `mask_bit`.
- R2: A source latches a request only when its `src_en` bit is 1. Clearing that bit drops a pending request, so it is never accepted afterwards.
- R3: In fixed mode, the programmed priorities have no effect. The lowest-numbered eligible source wins, and the reported level is 0.
- R4: In fixed mode, while `mask_bit` is 1, no maskable source is accepted. Its request stays pending and is accepted once `mask_bit` returns to 0.
- R5: Only the winning request is presented. The other pending requests stay latched and are presented later, after the winner is acknowledged.
- R6: `cpu_req` rises on the cycle after a clock edge that sees `insn_end` = 1 with at least one eligible request. It never rises without such an edge.
- R7: While `cpu_req` is 1, `new_mask_bit` is 1 and `new_mask_lvl` equals `cpu_lvl`.
- R8: In level mode, a maskable source is eligible only if its priority (bits 3i+2..3i of `src_prio`) is strictly greater than `mask_lvl`. The highest priority wins. On a tie, the lower index wins.
- R9: A rising edge on `nmi_in` creates exactly one non-maskable request. This request ignores both masks and beats every other source. It is presented with vector `VEC_NMI` (7) and level 7.
- R10: After reset, `cpu_req` is 0. Once raised, `cpu_req`, `cpu_vec` and `cpu_lvl` hold until the edge that sees `cpu_ack` = 1. At that edge the winner's pending bit is cleared, and `cpu_req` is 0 afterwards.
- R11: A maskable source i is presented with vector `VEC_BASE` + i (default 64 + i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | N_SRC | Request line of each maskable source |
| src_en | input | N_SRC | Enable bit of each maskable source |
| mode_sel | input | 1 | 0 = fixed mode, 1 = level mode |
| src_prio | input | 3*N_SRC | Programmed 3-bit priority of each source |
| mask_bit | input | 1 | CPU single mask bit (fixed mode) |
| mask_lvl | input | 3 | CPU mask level (level mode) |
| insn_end | input | 1 | Instruction-boundary strobe |
| nmi_in | input | 1 | Non-maskable request line (edge-sensitive) |
| cpu_ack | input | 1 | CPU takes the presented request |
| cpu_req | output | 1 | Request presented to the CPU |
| cpu_vec | output | VEC_W | Vector number of the presented request |
| cpu_lvl | output | 3 | Level of the presented request |
| new_mask_bit | output | 1 | Mask bit for the CPU to load on acceptance |
| new_mask_lvl | output | 3 | Mask level for the CPU to load on acceptance |

## Verification
The hardest case to reach is a request that stays latched across other events and is then taken at the right moment. Examples are a source parked under a set mask bit, a source withdrawn by its enable while still pending, and a pending source that is overtaken by a non-maskable edge. Each of these needs a specific order of request, enable, mask, strobe and acknowledge over several cycles. Directed sequences build each of these orders on purpose. Long random runs then mix mode switches, mask changes, sparse strobes and delayed acknowledges, and a cycle-level reference model predicts every presented request.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_TOP = '1;

  typedef enum logic {
    MODE_FIXED = 1'b0,
    MODE_LEVEL = 1'b1
  } mask_mode_e;

  // Level a source competes with: programmed in level mode, flat in fixed mode.
  function automatic lvl_t eff_level(mask_mode_e m, lvl_t prog);
    return (m == MODE_LEVEL) ? prog : '0;
  endfunction

  // Whether a maskable source gets past the CPU mask in the current mode.
  function automatic logic passes_mask(mask_mode_e m, lvl_t lvl, logic mbit, lvl_t mlvl);
    return (m == MODE_LEVEL) ? (lvl > mlvl) : !mbit;
  endfunction

  // Candidate replaces the current best only on a strictly higher level,
  // so a scan from index 0 upward keeps the lower index on a tie.
  function automatic logic outranks(logic have, lvl_t cand, lvl_t best);
    return !have || (cand > best);
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] clr_src,
  input  logic             nmi_in,
  input  logic             clr_nmi,
  output logic [N_SRC-1:0] pend,
  output logic             nmi_pend,
  output logic             nmi_edge
);
  logic nmi_q;

  assign nmi_edge = nmi_in & ~nmi_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_latch
    always_ff @(posedge clk) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= src_en[i] & (src_req[i] | (pend[i] & ~clr_src[i]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_in;
      nmi_pend <= nmi_edge | (nmi_pend & ~clr_nmi);
    end
  end
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  mask_mode_e             mode,
  input  logic [N_SRC-1:0]       pend,
  input  logic [N_SRC-1:0]       src_en,
  input  logic [N_SRC*LVL_W-1:0] src_prio,
  input  logic                   mask_bit,
  input  lvl_t                   mask_lvl,
  input  logic                   nmi_pend,
  output logic                   any_elig,
  output logic                   sel_nmi,
  output logic [IDX_W-1:0]       sel_idx,
  output lvl_t                   sel_lvl
);
  lvl_t             eff [N_SRC];
  logic [N_SRC-1:0] elig;
  logic             have;
  lvl_t             best;
  logic [IDX_W-1:0] bidx;

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign eff[i]  = eff_level(mode, src_prio[i*LVL_W +: LVL_W]);
    assign elig[i] = pend[i] & src_en[i] & passes_mask(mode, eff[i], mask_bit, mask_lvl);
  end

  always_comb begin
    have = 1'b0;
    best = '0;
    bidx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && outranks(have, eff[i], best)) begin
        have = 1'b1;
        best = eff[i];
        bidx = IDX_W'(i);
      end
    end
  end

  assign any_elig = have | nmi_pend;
  assign sel_nmi  = nmi_pend;
  assign sel_idx  = bidx;
  assign sel_lvl  = nmi_pend ? LVL_TOP : best;
endmodule

// File: rtl/irq_grant_reg.sv
module irq_grant_reg
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_end,
  input  logic             any_elig,
  input  logic             sel_nmi,
  input  logic [IDX_W-1:0] sel_idx,
  input  lvl_t             sel_lvl,
  input  logic             cpu_ack,
  output logic             cpu_req,
  output logic             g_nmi,
  output logic [IDX_W-1:0] g_idx,
  output lvl_t             g_lvl,
  output logic             accept,
  output logic             retire
);
  assign accept = !cpu_req && insn_end && any_elig;
  assign retire = cpu_req && cpu_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_req <= 1'b0;
      g_nmi   <= 1'b0;
      g_idx   <= '0;
      g_lvl   <= '0;
    end else if (accept) begin
      cpu_req <= 1'b1;
      g_nmi   <= sel_nmi;
      g_idx   <= sel_idx;
      g_lvl   <= sel_lvl;
    end else if (retire) begin
      cpu_req <= 1'b0;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_NMI  = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       src_req,
  input  logic [N_SRC-1:0]       src_en,
  input  logic                   mode_sel,
  input  logic [N_SRC*LVL_W-1:0] src_prio,
  input  logic                   mask_bit,
  input  logic [LVL_W-1:0]       mask_lvl,
  input  logic                   insn_end,
  input  logic                   nmi_in,
  input  logic                   cpu_ack,
  output logic                   cpu_req,
  output logic [VEC_W-1:0]       cpu_vec,
  output logic [LVL_W-1:0]       cpu_lvl,
  output logic                   new_mask_bit,
  output logic [LVL_W-1:0]       new_mask_lvl
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  mask_mode_e       mode;
  logic [N_SRC-1:0] pend, clr_src;
  logic             nmi_pend, nmi_edge, clr_nmi;
  logic             any_elig, sel_nmi;
  logic [IDX_W-1:0] sel_idx, g_idx;
  lvl_t             sel_lvl, g_lvl;
  logic             g_nmi, accept, retire;

  assign mode = mask_mode_e'(mode_sel);

  irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
    .clr_src(clr_src), .nmi_in(nmi_in), .clr_nmi(clr_nmi),
    .pend(pend), .nmi_pend(nmi_pend), .nmi_edge(nmi_edge)
  );

  irq_select #(.N_SRC(N_SRC)) u_sel (
    .mode(mode), .pend(pend), .src_en(src_en), .src_prio(src_prio),
    .mask_bit(mask_bit), .mask_lvl(mask_lvl), .nmi_pend(nmi_pend),
    .any_elig(any_elig), .sel_nmi(sel_nmi), .sel_idx(sel_idx), .sel_lvl(sel_lvl)
  );

  irq_grant_reg #(.N_SRC(N_SRC)) u_grant (
    .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .any_elig(any_elig),
    .sel_nmi(sel_nmi), .sel_idx(sel_idx), .sel_lvl(sel_lvl), .cpu_ack(cpu_ack),
    .cpu_req(cpu_req), .g_nmi(g_nmi), .g_idx(g_idx), .g_lvl(g_lvl),
    .accept(accept), .retire(retire)
  );

  // Retiring a grant clears only the winner's latch.
  for (genvar i = 0; i < N_SRC; i++) begin : g_clr
    assign clr_src[i] = retire & ~g_nmi & (g_idx == IDX_W'(i));
  end
  assign clr_nmi = retire & g_nmi;

  assign cpu_vec      = g_nmi ? VEC_W'(VEC_NMI) : VEC_W'(VEC_BASE) + VEC_W'(g_idx);
  assign cpu_lvl      = g_lvl;
  assign new_mask_bit = cpu_req;
  assign new_mask_lvl = g_lvl;
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int N_SRC = 8,
  parameter int VEC_W = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_en,
  input logic             mode_sel,
  input logic             mask_bit,
  input logic [2:0]       mask_lvl,
  input logic             insn_end,
  input logic             cpu_ack,
  input logic             cpu_req,
  input logic [VEC_W-1:0] cpu_vec,
  input logic [2:0]       cpu_lvl,
  input logic             nmi_pend,
  input logic             g_nmi,
  input logic [IDX_W-1:0] g_idx
);
  logic [N_SRC-1:0] en_q;
  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= src_en;
  end

  a_r6_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_req) |-> $past(insn_end));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_ack |=> cpu_req && $stable(cpu_vec) && $stable(cpu_lvl));

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_ack |=> !cpu_req);

  a_r4_bit_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_req) && !g_nmi && !$past(mode_sel) |-> !$past(mask_bit));

  a_r8_above_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_req) && !g_nmi && $past(mode_sel) |-> cpu_lvl > $past(mask_lvl));

  a_r2_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_req) && !g_nmi |-> en_q[g_idx]);

  a_r9_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_req) && $past(nmi_pend) |-> g_nmi);
endmodule

bind prio_irq_ctrl irq_ctrl_checker #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_en(src_en), .mode_sel(mode_sel),
  .mask_bit(mask_bit), .mask_lvl(mask_lvl), .insn_end(insn_end),
  .cpu_ack(cpu_ack), .cpu_req(cpu_req), .cpu_vec(cpu_vec), .cpu_lvl(cpu_lvl),
  .nmi_pend(nmi_pend), .g_nmi(g_nmi), .g_idx(g_idx)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  localparam int N  = 8;
  localparam int VB = 64;
  localparam int VN = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n = 1'b0;
  logic [N-1:0]   req = '0, en = '0;
  logic           mode = 1'b0;
  logic [N*3-1:0] prio = '0;
  logic           mbit = 1'b0;
  logic [2:0]     mlvl = '0;
  logic           iend = 1'b0, nmi = 1'b0, ack = 1'b0;
  logic           cpu_req, nmb;
  logic [7:0]     cpu_vec;
  logic [2:0]     cpu_lvl, nml;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(req), .src_en(en), .mode_sel(mode),
    .src_prio(prio), .mask_bit(mbit), .mask_lvl(mlvl), .insn_end(iend),
    .nmi_in(nmi), .cpu_ack(ack), .cpu_req(cpu_req), .cpu_vec(cpu_vec),
    .cpu_lvl(cpu_lvl), .new_mask_bit(nmb), .new_mask_lvl(nml)
  );

  int  errors = 0, checks = 0;
  bit  done = 0;

  // Reference model state
  bit       m_req, m_gn, m_np, m_nq;
  int       m_gi, m_gl;
  bit [N-1:0] m_pend;

  function automatic int prio_of(int i);
    return int'(prio[i*3 +: 3]);
  endfunction

  function automatic void pick(output bit ok, output bit isn, output int idx, output int lvl);
    ok = 0; isn = 0; idx = 0; lvl = 0;
    if (m_np) begin ok = 1; isn = 1; lvl = 7; return; end
    if (!mode) begin
      if (mbit) return;
      for (int i = 0; i < N; i++)
        if (m_pend[i] && en[i]) begin ok = 1; idx = i; return; end
    end else begin
      for (int p = 7; p > int'(mlvl); p--)
        for (int i = 0; i < N; i++)
          if (m_pend[i] && en[i] && prio_of(i) == p) begin ok = 1; idx = i; lvl = p; return; end
    end
  endfunction

  always @(posedge clk) begin
    bit ok, isn; int idx, lvl;
    bit [N-1:0] cv; bit cn;
    if (!rst_n) begin
      m_req = 0; m_gn = 0; m_np = 0; m_nq = 0; m_gi = 0; m_gl = 0; m_pend = '0;
    end else begin
      pick(ok, isn, idx, lvl);
      cv = '0; cn = 0;
      if (m_req) begin
        if (ack) begin
          m_req = 0;
          if (m_gn) cn = 1; else cv[m_gi] = 1;
        end
      end else if (iend && ok) begin
        m_req = 1; m_gn = isn; m_gi = idx; m_gl = lvl;
      end
      m_pend = en & (req | (m_pend & ~cv));
      m_np   = (nmi & ~m_nq) | (m_np & ~cn);
      m_nq   = nmi;
    end
  end

  task automatic expect_eq(string t, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", t, got, exp);
    end
  endtask

  task automatic chk(string t);
    expect_eq({t, " cpu_req"}, int'(cpu_req), int'(m_req));
    if (m_req && cpu_req) begin
      expect_eq({t, " cpu_vec (R11)"}, int'(cpu_vec), m_gn ? VN : VB + m_gi);
      expect_eq({t, " cpu_lvl"}, int'(cpu_lvl), m_gl);
      expect_eq({t, " new_mask_bit (R7)"}, int'(nmb), 1);
      expect_eq({t, " new_mask_lvl (R7)"}, int'(nml), m_gl);
    end
  endtask

  task automatic tick(string t);
    @(posedge clk);
    @(negedge clk);
    chk(t);
  endtask

  task automatic do_ack(string t);
    ack = 1'b1; tick(t); ack = 1'b0;
  endtask

  initial begin
    #(300000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1301));
    @(negedge clk);
    repeat (3) tick("R10 reset");
    expect_eq("R10 reset cpu_req", int'(cpu_req), 0);
    rst_n = 1'b1;

    // R2: gated latch and withdrawal
    req[3] = 1'b1; tick("R2");
    req = '0; en = '1; iend = 1'b1; tick("R2"); tick("R2");
    expect_eq("R2 disabled request not latched", int'(cpu_req), 0);
    iend = 1'b0; req[3] = 1'b1; tick("R2");
    req = '0; en[3] = 1'b0; tick("R2");
    en[3] = 1'b1; iend = 1'b1; tick("R2"); tick("R2");
    expect_eq("R2 withdrawn request", int'(cpu_req), 0);

    // R3: fixed order ignores programmed priority
    iend = 1'b0; prio[5*3 +: 3] = 3'd7;
    req[5] = 1'b1; req[2] = 1'b1; tick("R3");
    req = '0; iend = 1'b1; tick("R3");
    expect_eq("R3 lowest index wins", int'(cpu_vec), 66);
    expect_eq("R3 level zero", int'(cpu_lvl), 0);
    // R5: loser stays pending
    do_ack("R5"); tick("R5");
    expect_eq("R5 held request follows", int'(cpu_vec), 69);
    do_ack("R5");

    // R4: mask bit parks a request
    mbit = 1'b1; req[1] = 1'b1; tick("R4"); req = '0;
    repeat (4) tick("R4");
    expect_eq("R4 masked", int'(cpu_req), 0);
    mbit = 1'b0; tick("R4");
    expect_eq("R4 released", int'(cpu_vec), 65);
    expect_eq("R7 new mask bit", int'(nmb), 1);
    do_ack("R4");

    // R6: boundary strobe required
    iend = 1'b0; req[0] = 1'b1; tick("R6"); req = '0;
    repeat (3) tick("R6");
    expect_eq("R6 no strobe", int'(cpu_req), 0);
    iend = 1'b1; tick("R6");
    expect_eq("R6 strobe", int'(cpu_vec), 64);
    do_ack("R6");

    // R8: level mode
    mode = 1'b1; iend = 1'b0; mlvl = 3'd5;
    prio = '0; prio[0 +: 3] = 3'd3; prio[4*3 +: 3] = 3'd6; prio[6*3 +: 3] = 3'd6;
    req[0] = 1'b1; req[4] = 1'b1; req[6] = 1'b1; tick("R8");
    req = '0; iend = 1'b1; tick("R8");
    expect_eq("R8 tie lower index", int'(cpu_vec), 68);
    expect_eq("R8 level", int'(cpu_lvl), 6);
    expect_eq("R7 new mask level", int'(nml), 6);
    do_ack("R8");
    mlvl = 3'd6; tick("R8");
    expect_eq("R8 equal level blocked", int'(cpu_req), 0);
    mlvl = 3'd5; tick("R8");
    expect_eq("R8 next", int'(cpu_vec), 70);
    do_ack("R8");
    mlvl = 3'd2; tick("R8");
    expect_eq("R8 low source", int'(cpu_vec), 64);
    do_ack("R8");

    // R1: level mode ignores mask bit
    mbit = 1'b1; mlvl = 3'd0; prio[3*3 +: 3] = 3'd2; iend = 1'b0;
    req[3] = 1'b1; tick("R1"); req = '0; iend = 1'b1; tick("R1");
    expect_eq("R1 mask bit ignored in level mode", int'(cpu_vec), 67);
    do_ack("R1");

    // R9: non-maskable edge
    mode = 1'b0; mbit = 1'b1; req[2] = 1'b1; nmi = 1'b1; tick("R9"); req = '0; tick("R9");
    expect_eq("R9 nmi vector", int'(cpu_vec), VN);
    expect_eq("R9 nmi level", int'(cpu_lvl), 7);
    do_ack("R9");
    repeat (4) tick("R9");
    expect_eq("R9 single acceptance", int'(cpu_req), 0);
    nmi = 1'b0; tick("R9"); mbit = 1'b0; tick("R9");
    expect_eq("R9 parked source after", int'(cpu_vec), 66);
    do_ack("R9");

    // Random mix
    for (int c = 0; c < 4000; c++) begin
      req  = N'($urandom & $urandom & $urandom);
      if ($urandom % 16 == 0) en = N'($urandom | $urandom);
      else if ($urandom % 8 == 0) en = '1;
      if ($urandom % 150 == 0) mode = ~mode;
      if ($urandom % 40 == 0) prio = (N*3)'({$urandom, $urandom});
      if ($urandom % 10 == 0) mbit = $urandom % 3 == 0;
      if ($urandom % 10 == 0) mlvl = 3'($urandom);
      iend = ($urandom % 2) == 0;
      if ($urandom % 25 == 0) nmi = ~nmi;
      ack  = cpu_req ? ($urandom % 3 == 0) : ($urandom % 8 == 0);
      tick("R5/R8/R9/R1 random");
    end
    ack = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule